// File: doc/BRIEF.md
# In-Band Address Routed Cell Demultiplexer

This block receives fixed-length cells from one shared input bus and steers each cell into one of four internal cell queues. The sender precedes every cell with a routing word on the same bus. A word is treated as a routing word when the bus is enabled, the start-of-cell strobe is low and no cell is being received. The block latches that routing word and writes nothing into any queue for it. On the next cycle the block raises a cell-available flag if the addressed queue can hold a whole cell. If the sender then presents the first data word with the strobe high, the complete cell is stored in that queue.

The controller is a three-state machine. `ST_WAIT_ADDR` is the idle state, and the available flag is low in it. The transition *latch* (enable low, strobe low) moves it to `ST_ADDR_HELD`. In `ST_ADDR_HELD` the flag reflects room in the addressed queue. Three transitions leave or loop on this state:
- *relatch*: a new routing word is presented, and the machine stays in `ST_ADDR_HELD`.
- *reject*: the strobe is high while the flag is low. The word is dropped and the machine stays in `ST_ADDR_HELD`.
- *accept*: the strobe is high while the flag is high. The first word is written and the machine enters `ST_IN_CELL`.

In `ST_IN_CELL` every enabled cycle writes one word. A disabled cycle is a *stall* and transfers nothing. Writing the last word is the *finish* transition back to `ST_WAIT_ADDR`.

Each queue has a show-ahead read port. Its read data is the oldest word. It also provides an empty flag and a count of complete cells that are stored and not yet fully read.

Top module: `in_band_cell_demux`

## Requirements
- R1: With enable low, strobe low and no cell in progress, the bus word is latched as a routing value and no queue is written.
- R2: In the cycle after a routing word for queue 0 to 3, `cell_avail` is high when that queue has at least CELL_LEN (default 53) free words out of 128.
- R3: When the strobe is high and `cell_avail` is high, that word and the next CELL_LEN-1 enabled words are written in order to the addressed queue. Its complete-cell count rises by one after the last word.
- R4: A cycle inside a cell with `bus_en_n` high transfers no word, and the position within the cell holds.
- R5: When the addressed queue has fewer than CELL_LEN free words, `cell_avail` is low, and a strobe-high word is ignored.
- R6: After a rejection, a new routing word may be presented, followed by a retry of the first word with the strobe high.
- R7: A routing value of 4 or more selects no queue and forces `cell_avail` low.
- R8: `cell_avail` is low while no routing word is held. After the last word of a cell, the block waits for a new routing word.
- R9: A read enable on a non-empty queue pops the oldest word. The queue's cell count drops by one when the last word of a cell is popped, and `q_empty` rises when no words remain.
- R10: After reset, `cell_avail` is low, every queue is empty and every cell count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the bus side and the read side |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en_n | input | 1 | Active-low word enable for the input bus |
| bus_soc | input | 1 | Start-of-cell strobe, high on the first data word |
| bus_data | input | 9 | Shared routing/data word |
| cell_avail | output | 1 | Addressed queue can take a whole cell |
| q_rd_en | input | 4 | Per-queue pop request |
| q_rd_data | output | 36 | Per-queue oldest word, queue n at bits 9n+8..9n |
| q_empty | output | 4 | Per-queue empty flag |
| q_cells | output | 32 | Per-queue complete-cell count, queue n at bits 8n+7..8n |

## Verification
The bench fills queue 0 with two cells so that only 22 words remain free. It then checks that a third routing word to queue 0 leaves the flag low and that the strobed word is dropped. A design that compared free space against one word instead of a whole cell would accept this cell and overflow the queue. The bench also inserts disabled cycles in the middle of a cell and checks that the cell count rises only on the true last word. A design that advanced its position on stalls would close the cell early. Routing values of 4 and 5 are also sent, and a read-side drain verifies both word order and the moment the cell count drops.

// File: rtl/cell_demux_pkg.sv
package cell_demux_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_ADDR = 2'd0,
        ST_ADDR_HELD = 2'd1,
        ST_IN_CELL   = 2'd2
    } demux_state_e;
endpackage

// File: rtl/cell_queue.sv
module cell_queue #(
    parameter int DEPTH    = 128,
    parameter int WIDTH    = 9,
    parameter int CELL_LEN = 53,
    localparam int AW      = $clog2(DEPTH),
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int LW      = $clog2(CELL_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             cell_done,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic [CW-1:0]    free_words,
    output logic [CW-1:0]    cells
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    used;
    logic [LW-1:0]    rd_pos;
    logic             wr_ok, rd_ok, drain;

    assign wr_ok      = wr_en && (used != CW'(DEPTH));
    assign rd_ok      = rd_en && (used != '0);
    assign drain      = rd_ok && (rd_pos == LW'(CELL_LEN - 1));
    assign rd_data    = mem[rd_ptr];
    assign empty      = (used == '0);
    assign free_words = CW'(DEPTH) - used;

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
            rd_pos <= '0;
            cells  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (rd_ok) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
                rd_pos <= drain ? '0 : rd_pos + 1'b1;
            end
            used  <= used + CW'(wr_ok) - CW'(rd_ok);
            cells <= cells + CW'(cell_done) - CW'(drain);
        end
    end
endmodule

// File: rtl/demux_ctrl.sv
module demux_ctrl
    import cell_demux_pkg::*;
#(
    parameter int NUM_Q    = 4,
    parameter int WIDTH    = 9,
    parameter int CELL_LEN = 53,
    parameter int CW       = 8,
    localparam int QI      = $clog2(NUM_Q),
    localparam int LW      = $clog2(CELL_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic              soc,
    input  logic [WIDTH-1:0]  din,
    input  logic [NUM_Q*CW-1:0] free_vec,
    output logic              avail,
    output logic [NUM_Q-1:0]  wr_vec,
    output logic [NUM_Q-1:0]  done_vec,
    output demux_state_e      st,
    output logic [WIDTH-1:0]  addr_q
);
    demux_state_e  st_nx;
    logic [LW-1:0] pos;
    logic [CW-1:0] free_arr [NUM_Q];
    logic [QI-1:0] idx;
    logic          sel_ok, room, take, accept, in_write, last, write_now, end_now;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_free
        assign free_arr[q] = free_vec[q*CW +: CW];
    end

    assign idx      = addr_q[QI-1:0];
    assign sel_ok   = addr_q < WIDTH'(NUM_Q);
    assign room     = sel_ok && (free_arr[idx] >= CW'(CELL_LEN));
    assign take     = !en_n;
    assign accept   = (st == ST_ADDR_HELD) && take && soc && room;
    assign in_write = (st == ST_IN_CELL) && take;
    assign last     = (pos == LW'(CELL_LEN - 1));

    // next-state decision
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_WAIT_ADDR: if (take && !soc) st_nx = ST_ADDR_HELD;
            ST_ADDR_HELD: if (accept) st_nx = (CELL_LEN == 1) ? ST_WAIT_ADDR : ST_IN_CELL;
            ST_IN_CELL:   if (in_write && last) st_nx = ST_WAIT_ADDR;
            default:      st_nx = ST_WAIT_ADDR;
        endcase
    end

    // state register with routing latch and cell position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_WAIT_ADDR;
            addr_q <= '0;
            pos    <= '0;
        end else begin
            st <= st_nx;
            if (take && !soc && (st != ST_IN_CELL)) addr_q <= din;
            if (accept)        pos <= LW'(1);
            else if (in_write) pos <= pos + 1'b1;
        end
    end

    // outputs
    always_comb begin
        avail     = 1'b0;
        write_now = 1'b0;
        end_now   = 1'b0;
        unique case (st)
            ST_WAIT_ADDR: ;
            ST_ADDR_HELD: begin
                avail     = room;
                write_now = accept;
                end_now   = accept && (CELL_LEN == 1);
            end
            ST_IN_CELL: begin
                write_now = in_write;
                end_now   = in_write && last;
            end
            default: ;
        endcase
        for (int q = 0; q < NUM_Q; q++) begin
            wr_vec[q]   = write_now && (idx == QI'(q));
            done_vec[q] = end_now && (idx == QI'(q));
        end
    end
endmodule

// File: rtl/in_band_cell_demux.sv
module in_band_cell_demux
    import cell_demux_pkg::*;
#(
    parameter int NUM_Q    = 4,
    parameter int DEPTH    = 128,
    parameter int WIDTH    = 9,
    parameter int CELL_LEN = 53,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_en_n,
    input  logic                   bus_soc,
    input  logic [WIDTH-1:0]       bus_data,
    output logic                   cell_avail,
    input  logic [NUM_Q-1:0]       q_rd_en,
    output logic [NUM_Q*WIDTH-1:0] q_rd_data,
    output logic [NUM_Q-1:0]       q_empty,
    output logic [NUM_Q*CW-1:0]    q_cells
);
    demux_state_e      st;
    logic [WIDTH-1:0]  addr_q;
    logic [NUM_Q-1:0]  wr_vec, done_vec;
    logic [NUM_Q*CW-1:0] free_vec;

    demux_ctrl #(
        .NUM_Q(NUM_Q), .WIDTH(WIDTH), .CELL_LEN(CELL_LEN), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en_n(bus_en_n), .soc(bus_soc), .din(bus_data),
        .free_vec(free_vec), .avail(cell_avail), .wr_vec(wr_vec),
        .done_vec(done_vec), .st(st), .addr_q(addr_q)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        cell_queue #(
            .DEPTH(DEPTH), .WIDTH(WIDTH), .CELL_LEN(CELL_LEN)
        ) u_queue (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_vec[q]), .wr_data(bus_data), .cell_done(done_vec[q]),
            .rd_en(q_rd_en[q]), .rd_data(q_rd_data[q*WIDTH +: WIDTH]),
            .empty(q_empty[q]), .free_words(free_vec[q*CW +: CW]),
            .cells(q_cells[q*CW +: CW])
        );
    end
endmodule

// File: rtl/demux_checker.sv
module demux_checker
    import cell_demux_pkg::*;
#(
    parameter int NUM_Q = 4,
    parameter int WIDTH = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_n,
    input logic             soc,
    input logic             avail,
    input demux_state_e     st,
    input logic [WIDTH-1:0] addr_q,
    input logic [NUM_Q-1:0] wr_vec
);
    // R1
    routing_word_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT_ADDR && !en_n) |-> (wr_vec == '0));

    // R3
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IN_CELL && en_n) |-> (wr_vec == '0) ##1 (st == ST_IN_CELL));

    // R5
    reject_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR_HELD && !en_n && soc && !avail) |-> (wr_vec == '0) ##1 (st == ST_ADDR_HELD));

    // R7
    bad_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR_HELD && addr_q >= WIDTH'(NUM_Q)) |-> !avail);

    // R8
    idle_avail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_ADDR_HELD) |-> !avail);
endmodule

bind in_band_cell_demux demux_checker #(.NUM_Q(NUM_Q), .WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_n(bus_en_n), .soc(bus_soc), .avail(cell_avail),
    .st(st), .addr_q(addr_q), .wr_vec(wr_vec)
);

// File: tb/test_in_band_cell_demux.sv
module test_in_band_cell_demux;
    localparam int NQ = 4, WD = 9, CL = 53, CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en_n = 1'b1;
    logic          bus_soc = 1'b0;
    logic [WD-1:0] bus_data = '0;
    logic          cell_avail;
    logic [NQ-1:0] q_rd_en = '0;
    logic [NQ*WD-1:0] q_rd_data;
    logic [NQ-1:0] q_empty;
    logic [NQ*CW-1:0] q_cells;

    int checks = 0, fails = 0;
    int exp_cells [NQ];
    int q3_tag = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    in_band_cell_demux i_in_band_cell_demux (
        .clk(clk), .rst_n(rst_n), .bus_en_n(bus_en_n), .bus_soc(bus_soc),
        .bus_data(bus_data), .cell_avail(cell_avail), .q_rd_en(q_rd_en),
        .q_rd_data(q_rd_data), .q_empty(q_empty), .q_cells(q_cells)
    );

    // {routing value, expected available flag}
    localparam logic [9:0] VEC [8] = '{
        {9'd0, 1'b1}, {9'd1, 1'b1}, {9'd0, 1'b1}, {9'd0, 1'b0},
        {9'd5, 1'b0}, {9'd4, 1'b0}, {9'd3, 1'b1}, {9'd2, 1'b1}
    };

    function automatic logic [WD-1:0] word_of(int tag, int i);
        return WD'(tag * 37 + i * 3);
    endfunction

    function automatic int cells_of(int q);
        return int'(q_cells[q*CW +: CW]);
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic put(bit en_n, bit soc, logic [WD-1:0] d);
        bus_en_n = en_n;
        bus_soc  = soc;
        bus_data = d;
        @(negedge clk);
    endtask

    // sends a whole cell; stalls cycles of disabled bus after word stall_at
    task automatic send_cell(int tag, int stall_at, int stalls, int q);
        for (int i = 0; i < CL; i++) begin
            if (i == CL - 1) chk(cells_of(q) == exp_cells[q], "R4 count before last word", cells_of(q), exp_cells[q]);
            put(1'b0, i == 0, word_of(tag, i));
            if (i == stall_at)
                for (int s = 0; s < stalls; s++) put(1'b1, 1'b1, 9'h1FF);
        end
        put(1'b1, 1'b0, '0);
    endtask

    task automatic check_all_cells(string req);
        for (int q = 0; q < NQ; q++)
            chk(cells_of(q) == exp_cells[q], req, cells_of(q), exp_cells[q]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int q = 0; q < NQ; q++) exp_cells[q] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(cell_avail == 1'b0, "R10 avail", cell_avail, 0);
        chk(q_empty == 4'hF, "R10 empty", q_empty, 15);
        chk(q_cells == '0, "R10 cells", q_cells, 0);

        // table walk
        for (int v = 0; v < 8; v++) begin
            automatic int a = int'(VEC[v][9:1]);
            automatic bit e = VEC[v][0];
            automatic logic [NQ-1:0] empty_before = q_empty;
            put(1'b0, 1'b0, WD'(a));
            // R1: routing word alone writes nothing
            chk(q_empty == empty_before, "R1 routing word not stored", q_empty, empty_before);
            check_all_cells("R1 cells unchanged after routing word");
            if (a >= NQ) chk(cell_avail == 1'b0, "R7 out-of-range route", cell_avail, 0);
            else if (e)  chk(cell_avail == 1'b1, "R2 room for cell", cell_avail, 1);
            else         chk(cell_avail == 1'b0, "R5 queue lacks room", cell_avail, 0);
            if (e) begin
                if (a == 3) q3_tag = v;
                exp_cells[a]++;
                exp_cells[a]--;
                send_cell(v, -1, 0, a);
                exp_cells[a]++;
                check_all_cells("R3 cell stored");
                chk(cell_avail == 1'b0, "R8 avail low after cell", cell_avail, 0);
            end else begin
                put(1'b0, 1'b1, 9'h0AA);
                put(1'b1, 1'b0, '0);
                check_all_cells("R5 strobed word ignored");
                chk(cell_avail == 1'b0, "R5 avail stays low", cell_avail, 0);
            end
        end

        // R4 stall inside a cell on queue 1
        put(1'b0, 1'b0, 9'd1);
        chk(cell_avail == 1'b1, "R2 queue1 second cell", cell_avail, 1);
        send_cell(20, 20, 3, 1);
        exp_cells[1]++;
        chk(cells_of(1) == exp_cells[1], "R4 cell complete after stall", cells_of(1), exp_cells[1]);

        // R6 reject then retry with a new routing word
        put(1'b0, 1'b0, 9'd0);
        chk(cell_avail == 1'b0, "R6 first attempt rejected", cell_avail, 0);
        put(1'b0, 1'b1, 9'h055);
        chk(cell_avail == 1'b0, "R6 still waiting after reject", cell_avail, 0);
        put(1'b0, 1'b0, 9'd2);
        chk(cell_avail == 1'b1, "R6 retry route accepted", cell_avail, 1);
        send_cell(30, -1, 0, 2);
        exp_cells[2]++;
        check_all_cells("R6 retry stored in new queue");

        // R8 after a cell a plain word is a routing word again
        put(1'b0, 1'b0, 9'd3);
        chk(cell_avail == 1'b1, "R8 waits for routing word", cell_avail, 1);
        put(1'b1, 1'b0, '0);

        // R9 drain queue 3
        begin
            automatic int bad = 0;
            for (int i = 0; i < CL; i++) begin
                if (q_rd_data[3*WD +: WD] != word_of(q3_tag, i)) bad++;
                if (i == CL - 1)
                    chk(cells_of(3) == 1, "R9 count held until last pop", cells_of(3), 1);
                q_rd_en = 4'b1000;
                @(negedge clk);
            end
            q_rd_en = '0;
            chk(bad == 0, "R3 word order in queue3", bad, 0);
            chk(cells_of(3) == 0, "R9 count after drain", cells_of(3), 0);
            chk(q_empty[3] == 1'b1, "R9 empty after drain", q_empty[3], 1);
        end

        // R10 reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(q_empty == 4'hF, "R10 empty after reset", q_empty, 15);
        chk(q_cells == '0, "R10 cells after reset", q_cells, 0);
        chk(cell_avail == 1'b0, "R10 avail after reset", cell_avail, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule